// File: doc/BRIEF.md
# Receiver Gain Controller with Dwell Hold-Off

This block picks the gain state of a receiver front-end amplifier. It has two states, high and low gain. A comparator flag says when the received power is above the switching threshold. In high gain the block drops to low gain as soon as that flag is seen. It does not return to high gain at once when the power falls again. Instead it holds low gain for a dwell interval of 2^K crystal-clock cycles. It returns to high gain only if the power stays below the threshold for that whole interval. Without this hold, amplitude-keyed data whose marks sit above the threshold and whose spaces sit below it would flip the gain on every bit.

A 3-bit select code sets K. K is an odd exponent from 11 to 23. Code zero turns the gain control off, and the amplifier then stays in high gain. The comparator flag comes from an analog circuit with no tie to the clock, so it is resynchronised before use. The select code is treated as a static setting that is synchronous to the clock. A status output is high while a dwell countdown is running. The exponent offset is a parameter, so a scaled-down build can run short dwell intervals.

Top module: `agc_ctrl`

## Requirements
- R1: After reset, `gain_high` is 1 and `dwelling` is 0.
- R2: `above_thr` passes through a two-flop synchronizer. A change on the pin can affect the gain no earlier than the third rising clock edge after it.
- R3: In high gain with a nonzero select code, a synchronized above-threshold flag moves the block to low gain at the next edge. On the pin, this is the third edge after `above_thr` rises.
- R4: In low gain, when the synchronized flag is low, the block stays in low gain and sets `dwelling` to 1. On the pin, `dwelling` rises at the third edge after `above_thr` falls.
- R5: If the flag stays low, the block returns to high gain exactly 2^K clock edges after `dwelling` rises, and `dwelling` returns to 0 at that same edge.
- R6: The exponent is K = 2*code + EXP_OFFSET. With the default EXP_OFFSET of 9, codes 1 to 7 give K = 11, 13, 15, 17, 19, 21, 23.
- R7: If the flag rises again during a countdown, the countdown is dropped and `dwelling` goes to 0 while the gain stays low. A later fall starts a full new interval.
- R8: The select code is captured when a countdown starts. A change during the countdown does not alter that interval and applies to the next countdown.
- R9: Select code 000 forces `gain_high` to 1 and `dwelling` to 0 at the next edge, in any state and whatever `above_thr` is.
- R10: `dwelling` is never 1 while `gain_high` is 1.
- R11: The dwell counter is wide enough to reach 2^K for the largest code without wrapping. That is 24 bits with the default parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dwell_sel | input | 3 | Dwell exponent code; 000 turns the control off |
| above_thr | input | 1 | Asynchronous comparator flag, 1 when power is above threshold |
| gain_high | output | 1 | 1 selects high gain, 0 selects low gain |
| dwelling | output | 1 | 1 while a dwell countdown is running |

## Verification
Each result is due on a fixed edge. A change on `above_thr` reaches the gain or `dwelling` at the third rising edge after it. Release to high gain comes 2^K edges after that, and a change of select code to zero acts at the first edge. The bench drives every input on a falling edge and counts rising edges from there. It samples on the falling edge that follows the edge where a result is due. It also checks the edge just before, so a countdown that ends one cycle early or late fails. The bench build uses a reduced exponent offset so that the smallest and largest codes both finish within the run.

// File: rtl/agc_pkg.sv
// Shared types for the receiver gain controller.
// Assumes: nothing beyond a single clock domain for its users.
package agc_pkg;

    // Gain state of the front-end amplifier.
    typedef enum logic {
        GAIN_LOW  = 1'b0,
        GAIN_HIGH = 1'b1
    } gain_e;

endpackage

// File: rtl/agc_sync.sv
// Multi-stage flop synchronizer for one asynchronous level.
// Assumes: the input is a slow level, so a single bit needs no handshake.
module agc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the stage chain; reset to "below threshold".
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/agc_dwell_decode.sv
// Turns the select code into an enable and a dwell length of 2^K cycles.
// Assumes: K = 2*code + EXP_OFFSET fits in CNT_W-1 for every nonzero code.
module agc_dwell_decode #(
    parameter int SEL_W      = 3,
    parameter int EXP_OFFSET = 9,
    parameter int CNT_W      = 24
) (
    input  logic [SEL_W-1:0] sel,
    output logic             enable,
    output logic [CNT_W-1:0] length
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Code zero disables the control; otherwise length is a power of two.
    always_comb begin
        int k;
        k      = 2 * int'(sel) + EXP_OFFSET;
        enable = (sel != '0);
        length = enable ? (ONE << k) : '0;
    end
endmodule

// File: rtl/agc_dwell_timer.sv
// Dwell counter that captures its terminal length at start.
// Assumes: the caller issues at most one of start, step, clear per cycle.
module agc_dwell_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic             clear,
    input  logic [CNT_W-1:0] length_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Capture the length on start, advance on step, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            limit <= '0;
        end else if (start) begin
            count <= ONE;
            limit <= length_in;
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + ONE;
        end
    end

    assign expired = (count == limit);
endmodule

// File: rtl/agc_ctrl.sv
// Receiver gain controller: drops to low gain on an above-threshold flag,
// returns to high gain after 2^K cycles of continuous below-threshold power.
// Assumes: dwell_sel is static or synchronous to clk; above_thr is async.
module agc_ctrl #(
    parameter int SEL_W       = 3,
    parameter int EXP_OFFSET  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] dwell_sel,
    input  logic             above_thr,
    output logic             gain_high,
    output logic             dwelling
);
    import agc_pkg::*;

    localparam int MAX_EXP = 2 * ((1 << SEL_W) - 1) + EXP_OFFSET;
    localparam int CNT_W   = MAX_EXP + 1;

    logic             above_sync;
    logic             sel_en;
    logic [CNT_W-1:0] sel_len;
    logic [CNT_W-1:0] dwell_cnt;
    logic [CNT_W-1:0] dwell_lim;
    logic             dwell_done;
    gain_e            gain_q, gain_d;
    logic             active_q, active_d;
    logic             t_start, t_step, t_clear;

    agc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (above_thr),
        .q_sync  (above_sync)
    );

    agc_dwell_decode #(.SEL_W(SEL_W), .EXP_OFFSET(EXP_OFFSET), .CNT_W(CNT_W)) u_dec (
        .sel    (dwell_sel),
        .enable (sel_en),
        .length (sel_len)
    );

    agc_dwell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (t_start),
        .step      (t_step),
        .clear     (t_clear),
        .length_in (sel_len),
        .count     (dwell_cnt),
        .limit     (dwell_lim),
        .expired   (dwell_done)
    );

    // Next-state decision for gain and countdown activity.
    always_comb begin
        gain_d   = gain_q;
        active_d = active_q;
        t_start  = 1'b0;
        t_step   = 1'b0;
        t_clear  = 1'b0;
        if (!sel_en) begin
            gain_d   = GAIN_HIGH;
            active_d = 1'b0;
            t_clear  = 1'b1;
        end else if (gain_q == GAIN_HIGH) begin
            if (above_sync) gain_d = GAIN_LOW;
        end else if (above_sync) begin
            active_d = 1'b0;
            t_clear  = 1'b1;
        end else if (!active_q) begin
            active_d = 1'b1;
            t_start  = 1'b1;
        end else if (dwell_done) begin
            gain_d   = GAIN_HIGH;
            active_d = 1'b0;
            t_clear  = 1'b1;
        end else begin
            t_step = 1'b1;
        end
    end

    // State registers; reset enters high gain with no countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q   <= GAIN_HIGH;
            active_q <= 1'b0;
        end else begin
            gain_q   <= gain_d;
            active_q <= active_d;
        end
    end

    assign gain_high = (gain_q == GAIN_HIGH);
    assign dwelling  = active_q;
endmodule

// File: rtl/agc_ctrl_chk.sv
// Property checker for agc_ctrl, attached by bind below.
// Assumes: sampled signals are the top's ports and timer/synchronizer outputs.
module agc_ctrl_chk #(
    parameter int SEL_W = 3,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] sel,
    input logic             above_s,
    input logic             gain_high,
    input logic             dwelling,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim
);
    a_r9_disable_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> (gain_high && !dwelling));

    a_r3_attack_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_high && above_s && sel != '0) |=> !gain_high);

    a_r7_reassert_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!gain_high && above_s && sel != '0) |=> (!gain_high && !dwelling));

    a_r10_dwell_only_low: assert property (@(posedge clk) disable iff (!rst_n)
        dwelling |-> !gain_high);

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        dwelling |-> (cnt <= lim && cnt != '0));

    a_r8_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dwelling) && dwelling) |-> $stable(lim));

    a_r5_release_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (dwelling && !above_s && sel != '0 && cnt == lim) |=> (gain_high && !dwelling));
endmodule

bind agc_ctrl agc_ctrl_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (dwell_sel),
    .above_s   (above_sync),
    .gain_high (gain_high),
    .dwelling  (dwelling),
    .cnt       (dwell_cnt),
    .lim       (dwell_lim)
);

// File: tb/agc_ctrl_test.sv
module agc_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_OFF    = -1;   // code c -> K = 2c-1 -> 2^(2c-1) cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dwell_sel = 3'd0;
    logic       above_thr = 1'b0;
    logic       gain_high;
    logic       dwelling;
    int         n_run = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    agc_ctrl #(.SEL_W(3), .EXP_OFFSET(EXP_OFF), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dwell_sel (dwell_sel),
        .above_thr (above_thr),
        .gain_high (gain_high),
        .dwelling  (dwelling)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int dwell_len(input int code);
        return 1 << (2 * code + EXP_OFF);
    endfunction

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    // Bring the block into low gain with the given code.
    task automatic go_low(input logic [2:0] code);
        dwell_sel = code;
        above_thr = 1'b1;
        edges(3);
    endtask

    task automatic t_reset;
        chk("R1", "gain after reset", gain_high, 1'b1);
        chk("R1", "dwelling after reset", dwelling, 1'b0);
    endtask

    task automatic t_attack;
        dwell_sel = 3'd2;
        above_thr = 1'b1;
        edges(2);
        chk("R2", "gain still high two edges after flag", gain_high, 1'b1);
        edges(1);
        chk("R3", "gain low at third edge", gain_high, 1'b0);
        chk("R3", "no countdown while above", dwelling, 1'b0);
    endtask

    // Full countdown with the code already captured; starts from low gain.
    task automatic t_dwell(input logic [2:0] code, input string req);
        int len;
        len = dwell_len(int'(code));
        go_low(code);
        chk(req, "low before release", gain_high, 1'b0);
        above_thr = 1'b0;
        edges(2);
        chk("R4", "no countdown before sync delay", dwelling, 1'b0);
        edges(1);
        chk("R4", "countdown running", dwelling, 1'b1);
        chk("R4", "still low gain", gain_high, 1'b0);
        edges(len - 1);
        chk(req, "still low one edge before expiry", gain_high, 1'b0);
        chk("R10", "dwelling one edge before expiry", dwelling, 1'b1);
        edges(1);
        chk(req, "high gain at expiry", gain_high, 1'b1);
        chk("R5", "countdown ended", dwelling, 1'b0);
    endtask

    task automatic t_reassert;
        go_low(3'd2);
        above_thr = 1'b0;
        edges(6);
        chk("R7", "countdown running before reassert", dwelling, 1'b1);
        above_thr = 1'b1;
        edges(3);
        chk("R7", "countdown dropped", dwelling, 1'b0);
        chk("R7", "gain stays low", gain_high, 1'b0);
        edges(20);
        chk("R7", "gain low while above", gain_high, 1'b0);
        above_thr = 1'b0;
        edges(3 + dwell_len(2) - 1);
        chk("R7", "restarted interval is full length", gain_high, 1'b0);
        edges(1);
        chk("R7", "release after full new interval", gain_high, 1'b1);
    endtask

    task automatic t_code_change;
        go_low(3'd3);
        above_thr = 1'b0;
        edges(3);
        dwell_sel = 3'd1;
        edges(dwell_len(3) - 1);
        chk("R8", "old interval kept after code change", gain_high, 1'b0);
        edges(1);
        chk("R8", "release at captured interval", gain_high, 1'b1);
        t_dwell(3'd1, "R8");
    endtask

    task automatic t_disable;
        dwell_sel = 3'd0;
        above_thr = 1'b1;
        edges(12);
        chk("R9", "code 0 keeps high gain with flag set", gain_high, 1'b1);
        chk("R9", "code 0 no countdown", dwelling, 1'b0);
        go_low(3'd2);
        above_thr = 1'b0;
        edges(4);
        chk("R9", "countdown running before disable", dwelling, 1'b1);
        dwell_sel = 3'd0;
        edges(1);
        chk("R9", "disable forces high mid-countdown", gain_high, 1'b1);
        chk("R9", "disable ends countdown", dwelling, 1'b0);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_attack();
        t_dwell(3'd1, "R6");
        t_dwell(3'd2, "R5");
        t_dwell(3'd3, "R6");
        t_dwell(3'd7, "R11");
        t_reassert();
        t_code_change();
        t_disable();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule